// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a UART baud (or oversampling) enable pulse from the system clock. An integer prescaler first slows the clock by a programmable factor, and each prescaler enable then adds a 16-bit step into a 17-bit phase accumulator. Every time the accumulator overflows, the block emits a tick one clock wide. Over a long run, the average tick rate is the clock frequency divided by (scale+1), multiplied by step/2^17.

Software works out the best scale/step pair for a target rate. It then hands the block one 32-bit configuration word together with a one-cycle write strobe. Each write restarts the prescaler and clears the accumulator, so the first tick after a write always falls at a predictable point.

Top module: `fracBaudGen`

## Requirements
- R1: After reset, tick is low and stays low until a configuration write, because reset clears the prescaler count, the accumulator and the held step, and the step is held at zero.
- R2: The configuration word carries the scale in bits [27:16] and the step in bits [15:0]. Bits [31:28] have no effect on the tick stream.
- R3: The prescaler produces one accumulator enable every scale+1 clock cycles. A scale of 0 enables on every cycle.
- R4: Count clock edges from a write edge, with that edge as edge 0. Edge n, where n is a multiple of scale+1, is the k-th enable, with k = n/(scale+1). Tick is high for the cycle after that edge exactly when floor(k·step/2^17) exceeds floor((k-1)·step/2^17). In every other cycle tick is low.
- R5: A step of 0 produces no ticks for any scale.
- R6: A configuration write clears the accumulator and reloads the prescaler on its clock edge. Tick is low in the cycle after the write edge, and the enable count of R4 restarts from that edge.
- R7: After K enables since a write, the number of ticks seen is exactly floor(K·step/2^17). The accumulator keeps its remainder when it wraps.
- R8: Tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | One-cycle strobe that loads cfgWord |
| cfgWord | input | 32 | Configuration word: scale in [27:16], step in [15:0] |
| tick | output | 1 | Single-cycle baud enable pulse |

## Verification
A configuration write takes effect on its own edge, and tick is registered. The bench therefore treats the write edge as edge 0, expects tick low at the next falling edge, and expects each enable's carry on the falling edge after edge n = k·(scale+1). The bench drives its inputs and samples tick only on falling edges. It counts edges from the write itself and computes each expected value from the k·step/2^17 floor difference. At the end of each run it compares the total tick count with floor(K·step/2^17). The runs sweep several scales against a set of steps, including 0, 1, the half-scale value and the maximum, and finish with one long run at the largest scale.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CFG_W     = 32;
  localparam int SCALE_W   = 12;
  localparam int SCALE_LSB = 16;
  localparam int STEP_W    = 16;
  localparam int STEP_LSB  = 0;
  localparam int ACC_W     = STEP_W + 1;

  typedef struct packed {
    logic addEn;     // add step into accumulator this cycle
    logic clearAcc;  // configuration load: clear phase
  } ctrlStrobes_t;
endpackage

// File: rtl/baudCtrl.sv
module baudCtrl
  import baud_pkg::*;
#(
  parameter int SCALE_W_P = SCALE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic [SCALE_W_P-1:0] scaleIn,
  output ctrlStrobes_t         strobes
);
  logic [SCALE_W_P-1:0] scaleReg;
  logic [SCALE_W_P-1:0] presCnt;
  logic                 presHit;

  assign presHit = (presCnt == scaleReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleReg <= '0;
      presCnt  <= '0;
    end else if (cfgWrite) begin
      scaleReg <= scaleIn;
      presCnt  <= '0;
    end else if (presHit) begin
      presCnt  <= '0;
    end else begin
      presCnt  <= presCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.clearAcc = cfgWrite;
    strobes.addEn    = presHit && !cfgWrite;
  end
endmodule

// File: rtl/baudDatapath.sv
module baudDatapath
  import baud_pkg::*;
#(
  parameter int STEP_W_P = STEP_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrite,
  input  logic [STEP_W_P-1:0] stepIn,
  input  ctrlStrobes_t        strobes,
  output logic                tick
);
  localparam int AW = STEP_W_P + 1;

  logic [STEP_W_P-1:0] stepReg;
  logic [AW-1:0]       phaseAcc;
  logic [AW:0]         phaseSum;

  assign phaseSum = {1'b0, phaseAcc} + {{(AW + 1 - STEP_W_P){1'b0}}, stepReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepReg <= '0;
    end else if (cfgWrite) begin
      stepReg <= stepIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      tick     <= 1'b0;
    end else if (strobes.clearAcc) begin
      phaseAcc <= '0;
      tick     <= 1'b0;
    end else if (strobes.addEn) begin
      phaseAcc <= phaseSum[AW-1:0];
      tick     <= phaseSum[AW];
    end else begin
      tick     <= 1'b0;
    end
  end
endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             tick
);
  ctrlStrobes_t strobes;

  baudCtrl #(.SCALE_W_P(SCALE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrite (cfgWrite),
    .scaleIn  (cfgWord[SCALE_LSB +: SCALE_W]),
    .strobes  (strobes)
  );

  baudDatapath #(.STEP_W_P(STEP_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrite (cfgWrite),
    .stepIn   (cfgWord[STEP_LSB +: STEP_W]),
    .strobes  (strobes),
    .tick     (tick)
  );
endmodule

// File: rtl/fracBaudGen_chk.sv
module fracBaudGen_chk
  import baud_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrite,
  input logic [CFG_W-1:0] cfgWord,
  input logic             addEn,
  input logic             tick
);
  logic [STEP_W-1:0]  stepSeen;
  logic [SCALE_W-1:0] scaleSeen;
  logic [SCALE_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepSeen  <= '0;
      scaleSeen <= '0;
      gapCnt    <= '0;
    end else begin
      if (cfgWrite) begin
        stepSeen  <= cfgWord[STEP_LSB +: STEP_W];
        scaleSeen <= cfgWord[SCALE_LSB +: SCALE_W];
      end
      if (cfgWrite || addEn) gapCnt <= '0;
      else                   gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R8
  AST_WRITE_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !tick); // R6
  AST_ZERO_STEP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stepSeen == '0) |-> !tick); // R5
  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(addEn)); // R4
  AST_ENABLE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    addEn |-> (gapCnt == scaleSeen)); // R3
endmodule

bind fracBaudGen fracBaudGen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrite (cfgWrite),
  .cfgWord  (cfgWord),
  .addEn    (strobes.addEn),
  .tick     (tick)
);

// File: tb/fracBaudGen_tb.sv
module fracBaudGen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        tick;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  fracBaudGen u_dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgWord(cfgWord), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Load w on one edge, then follow `cycles` further edges against the arithmetic model.
  task automatic runCfg(input logic [31:0] w, input int cycles);
    longint sc = longint'(w[27:16]);
    longint st = longint'(w[15:0]);
    longint ticks = 0;
    longint kLast = 0;
    bit prev = 1'b0;
    @(negedge clk);
    cfgWord  = w;
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    check(tick == 1'b0, "R6", tick, 0);
    for (int n = 1; n <= cycles; n++) begin
      bit expT = 1'b0;
      @(negedge clk);
      if ((n % (sc + 1)) == 0) begin
        longint k = n / (sc + 1);
        expT = (((k * st) >> 17) != (((k - 1) * st) >> 17));
        kLast = k;
      end
      // R3/R4: enable every scale+1 edges, tick on carry
      check(tick == expT, (st == 0) ? "R5" : "R4", tick, expT);
      check(!(prev && tick), "R8", tick, 0);
      prev = tick;
      if (tick) ticks++;
    end
    check(ticks == ((kLast * st) >> 17), "R7", ticks, (kLast * st) >> 17);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int scales[4] = '{0, 1, 2, 5};
    int steps[6]  = '{0, 1, 'h8000, 'hFFFF, 'h5A5A, 'h1234};
    bit sawTick = 1'b0;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1", tick, 0);
    rstN = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick) sawTick = 1'b1;
    end
    check(sawTick == 1'b0, "R1", sawTick, 0);

    foreach (scales[a]) foreach (steps[b])
      runCfg({4'h0, 12'(scales[a]), 16'(steps[b])}, 400);

    // R2: junk in [31:28] must leave the stream unchanged
    runCfg({4'hF, 12'd3, 16'hC001}, 400);
    runCfg({4'hA, 12'd0, 16'hFFFF}, 300);
    // R6: rewrite part way through a run restarts the phase
    runCfg({4'h0, 12'd2, 16'h7000}, 37);
    runCfg({4'h0, 12'd2, 16'h7000}, 200);
    // R3: largest scale
    runCfg({4'h0, 12'hFFF, 16'hFFFF}, 3 * 4096 + 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule